// File: doc/BRIEF.md
# Charge Pump Phase Sequencer

This block is the digital controller of a switched-capacitor boost stage that lifts a battery supply to one and a half times its value. It drives seven switch enables in two groups. The charge group (S1, S2, S3) puts both flying capacitors across the supply. The transfer group (S4, S5, S6, S7) stacks the capacitors on top of the supply and feeds the output. The two groups take turns at a fixed rate set by clock-count parameters. Every change between groups passes through a dead interval in which all seven enables are low. The analog comparators, the capacitors and the power switches lie outside the block and reach it only as input flags.

After enable, a soft-start interval shortens each transfer pulse, which limits the charge moved per cycle and so the inrush current. When the supply is flagged high, the block regulates with the over-voltage comparator. That comparator has its hysteresis in the analog domain. While it trips, the block stays in the charge phase and skips transfer pulses, so the fixed ratio no longer sets the output. An over-current flag cuts a transfer pulse short. A power-good flag reports a settled, fault-free pump.

Top module: `cp_phase_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `sw_en` is 0, `ss_active` is 0 and `pgood` is 0.
- R2: Bit i of `sw_en` drives switch S(i+1). The charge phase is `sw_en` = 7'b0000111 for CHG_CYC cycles. The transfer phase is `sw_en` = 7'b1111000 for XFR_CYC cycles once soft-start is over.
- R3: The two groups are never on together. No group turns on unless `sw_en` was 0 for at least DEAD_CYC cycles just before.
- R4: Once `en` is sampled high, the pump runs in the order DEAD_CYC idle cycles, charge, DEAD_CYC idle cycles, transfer, DEAD_CYC idle cycles, charge, and repeats.
- R5: `ss_active` rises in the cycle after `en` is first sampled high and stays high for exactly SS_CYC cycles. While it is high, each transfer phase lasts SS_XFR_CYC cycles.
- R6: If `ovp` and `vdd_hi` are both high at the last cycle of a charge phase, the charge phase goes on until that condition clears, and no transfer pulse occurs. When `vdd_hi` is low, `ovp` has no effect on `sw_en`.
- R7: When `ocp` is high during a transfer cycle, `sw_en` is 0 from the next cycle. After DEAD_CYC idle cycles a charge phase follows.
- R8: `pgood` is high exactly when the pump is running, `en` is high, soft-start has finished and neither `ocp` nor `ovp` is high. It follows `ocp` and `ovp` in the same cycle.
- R9: When `en` is sampled low, `sw_en`, `ss_active` and `pgood` are all 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Pump enable |
| vdd_hi | input | 1 | Supply-above-threshold comparator flag |
| ovp | input | 1 | Output over-voltage comparator flag |
| ocp | input | 1 | Over-current flag |
| sw_en | output | 7 | Switch enables, bit i for switch S(i+1) |
| ss_active | output | 1 | Soft-start in progress |
| pgood | output | 1 | Output settled and fault-free |

## Verification
The sequencing flags `en`, `ovp` with `vdd_hi`, and `ocp` act on the phase state at the next rising edge, so their effect on `sw_en` and `ss_active` shows one cycle later. `pgood` reacts to `ocp` and `ovp` within the same cycle. The bench holds a cycle-level expectation of the phase and the soft-start count, advanced at each rising edge. At each falling edge it compares all three outputs against that expectation before it applies new inputs. That order keeps the combinational `pgood` path and the registered switch path in the cycles where each is due.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_LEAD,
      ST_CHG,
      ST_GAP,
      ST_XFR
   } cp_state_e;

   localparam int unsigned NSW = 7;
   localparam logic [NSW-1:0] CHG_GROUP = 7'b0000111;

endpackage

// File: rtl/cp_ss_timer.sv
module cp_ss_timer #(
   parameter int unsigned SS_CYC = 58080
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic run,
   output logic ss_active,
   output logic ss_done
);
   localparam int unsigned SW = $clog2(SS_CYC + 1);
   localparam logic [SW-1:0] SS_END = SW'(SS_CYC);

   initial begin
      if (SS_CYC < 1) $error("cp_ss_timer: SS_CYC must be at least 1");
   end

   logic [SW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en || !run) begin
         cnt_q <= '0;
      end else if (cnt_q != SS_END) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ss_done   = run && (cnt_q == SS_END);
   assign ss_active = run && (cnt_q != SS_END);

endmodule

// File: rtl/cp_phase_fsm.sv
module cp_phase_fsm
   import cp_seq_pkg::*;
#(
   parameter int unsigned CHG_CYC    = 20,
   parameter int unsigned XFR_CYC    = 20,
   parameter int unsigned SS_XFR_CYC = 6,
   parameter int unsigned DEAD_CYC   = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  logic      ovp_hold,
   input  logic      ocp,
   input  logic      ss_active,
   output cp_state_e state
);
   localparam int unsigned MAXLEN =
      (CHG_CYC > XFR_CYC) ? ((CHG_CYC > DEAD_CYC) ? CHG_CYC : DEAD_CYC)
                          : ((XFR_CYC > DEAD_CYC) ? XFR_CYC : DEAD_CYC);
   localparam int unsigned CW = $clog2(MAXLEN + 1);
   localparam logic [CW-1:0] CHG_LAST  = CW'(CHG_CYC - 1);
   localparam logic [CW-1:0] XFR_LAST  = CW'(XFR_CYC - 1);
   localparam logic [CW-1:0] SXFR_LAST = CW'(SS_XFR_CYC - 1);
   localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);

   initial begin
      if (DEAD_CYC < 2)   $error("cp_phase_fsm: DEAD_CYC must be at least 2");
      if (CHG_CYC < 1)    $error("cp_phase_fsm: CHG_CYC must be at least 1");
      if (SS_XFR_CYC < 1) $error("cp_phase_fsm: SS_XFR_CYC must be at least 1");
      if (SS_XFR_CYC > XFR_CYC)
         $error("cp_phase_fsm: SS_XFR_CYC must not exceed XFR_CYC");
   end

   cp_state_e st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic [CW-1:0] xfr_last;

   assign xfr_last = ss_active ? SXFR_LAST : XFR_LAST;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q + 1'b1;
      if (!en) begin
         st_d  = ST_OFF;
         cnt_d = '0;
      end else begin
         unique case (st_q)
            ST_OFF: begin
               st_d  = ST_LEAD;
               cnt_d = '0;
            end
            ST_LEAD: if (cnt_q == DEAD_LAST) begin
               st_d  = ST_CHG;
               cnt_d = '0;
            end
            ST_CHG: if (cnt_q == CHG_LAST) begin
               if (ovp_hold) begin
                  cnt_d = cnt_q;
               end else begin
                  st_d  = ST_GAP;
                  cnt_d = '0;
               end
            end
            ST_GAP: if (cnt_q == DEAD_LAST) begin
               st_d  = ST_XFR;
               cnt_d = '0;
            end
            ST_XFR: if (ocp || (cnt_q == xfr_last)) begin
               st_d  = ST_LEAD;
               cnt_d = '0;
            end
            default: begin
               st_d  = ST_OFF;
               cnt_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_OFF;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state = st_q;

   a_r6_hold_charge : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CHG && en && ovp_hold) |=> (st_q == ST_CHG));

endmodule

// File: rtl/cp_sw_map.sv
module cp_sw_map
   import cp_seq_pkg::*;
(
   input  cp_state_e      state,
   output logic [NSW-1:0] sw_en
);
   logic chg_on, xfr_on;

   assign chg_on = (state == ST_CHG);
   assign xfr_on = (state == ST_XFR);

   for (genvar i = 0; i < NSW; i++) begin : g_sw
      if (CHG_GROUP[i]) begin : g_chg
         assign sw_en[i] = chg_on;
      end else begin : g_xfr
         assign sw_en[i] = xfr_on;
      end
   end

endmodule

// File: rtl/cp_phase_seq.sv
module cp_phase_seq
   import cp_seq_pkg::*;
#(
   parameter int unsigned CHG_CYC    = 20,
   parameter int unsigned XFR_CYC    = 20,
   parameter int unsigned SS_XFR_CYC = 6,
   parameter int unsigned DEAD_CYC   = 2,
   parameter int unsigned SS_CYC     = 58080
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       vdd_hi,
   input  logic       ovp,
   input  logic       ocp,
   output logic [6:0] sw_en,
   output logic       ss_active,
   output logic       pgood
);
   localparam int unsigned IW = $clog2(DEAD_CYC + 2);
   localparam logic [IW-1:0] IDLE_SAT = IW'(DEAD_CYC + 1);

   cp_state_e state;
   logic      run, ss_done;

   assign run = (state != ST_OFF);

   cp_ss_timer #(.SS_CYC(SS_CYC)) ss_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .run       (run),
      .ss_active (ss_active),
      .ss_done   (ss_done)
   );

   cp_phase_fsm #(
      .CHG_CYC    (CHG_CYC),
      .XFR_CYC    (XFR_CYC),
      .SS_XFR_CYC (SS_XFR_CYC),
      .DEAD_CYC   (DEAD_CYC)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .ovp_hold  (ovp && vdd_hi),
      .ocp       (ocp),
      .ss_active (ss_active),
      .state     (state)
   );

   cp_sw_map map_i (
      .state (state),
      .sw_en (sw_en)
   );

   assign pgood = ss_done && en && !ocp && !ovp;

   // Checker state: consecutive all-off cycles seen before the present one.
   logic          chg_any, xfr_any;
   logic [IW-1:0] idle_run;

   assign chg_any = |(sw_en & CHG_GROUP);
   assign xfr_any = |(sw_en & ~CHG_GROUP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 idle_run <= '0;
      else if (sw_en != '0)       idle_run <= '0;
      else if (idle_run != IDLE_SAT) idle_run <= idle_run + 1'b1;
   end

   a_r3_no_overlap : assert property (@(posedge clk) disable iff (!rst_n)
      !(chg_any && xfr_any));

   a_r3_dead_gap : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(chg_any) || $rose(xfr_any)) |-> (idle_run >= IW'(DEAD_CYC)));

   a_r7_ocp_cut : assert property (@(posedge clk) disable iff (!rst_n)
      (xfr_any && ocp) |=> (sw_en == '0));

   a_r9_disable : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (sw_en == '0 && !ss_active && !pgood));

   a_r8_pgood_clean : assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> (!ocp && !ovp && !ss_active && en));

   a_r5_ss_start : assert property (@(posedge clk) disable iff (!rst_n)
      (!run && en) |=> ss_active);

endmodule

// File: tb/cp_phase_seq_tb_top.sv
module cp_phase_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CHG  = 5;
   localparam int XFR  = 6;
   localparam int SXFR = 2;
   localparam int DEAD = 2;
   localparam int SS   = 200;
   localparam int WATCHDOG = 150000;

   localparam int M_OFF = 0, M_LEAD = 1, M_CHG = 2, M_GAP = 3, M_XFR = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, vdd_hi = 1'b0, ovp = 1'b0, ocp = 1'b0;
   logic [6:0] sw_en;
   logic ss_active, pgood;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   string cur_req = "R1";

   int m_st = M_OFF;
   int m_cnt = 0;
   int m_ss = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cp_phase_seq #(
      .CHG_CYC(CHG), .XFR_CYC(XFR), .SS_XFR_CYC(SXFR),
      .DEAD_CYC(DEAD), .SS_CYC(SS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .vdd_hi(vdd_hi), .ovp(ovp), .ocp(ocp),
      .sw_en(sw_en), .ss_active(ss_active), .pgood(pgood)
   );

   // Expected behaviour advanced per rising edge, from the requirements.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st <= M_OFF; m_cnt <= 0; m_ss <= 0;
      end else begin
         if (!en || m_st == M_OFF) m_ss <= 0;
         else if (m_ss != SS) m_ss <= m_ss + 1;
         if (!en) begin
            m_st <= M_OFF; m_cnt <= 0;
         end else begin
            case (m_st)
               M_OFF:  begin m_st <= M_LEAD; m_cnt <= 0; end
               M_LEAD: if (m_cnt == DEAD-1) begin m_st <= M_CHG; m_cnt <= 0; end
                       else m_cnt <= m_cnt + 1;
               M_CHG:  if (m_cnt == CHG-1) begin
                          if (!(ovp && vdd_hi)) begin m_st <= M_GAP; m_cnt <= 0; end
                       end else m_cnt <= m_cnt + 1;
               M_GAP:  if (m_cnt == DEAD-1) begin m_st <= M_XFR; m_cnt <= 0; end
                       else m_cnt <= m_cnt + 1;
               default: if (ocp || m_cnt == ((m_ss != SS) ? SXFR : XFR) - 1) begin
                          m_st <= M_LEAD; m_cnt <= 0;
                       end else m_cnt <= m_cnt + 1;
            endcase
         end
      end
   end

   function automatic logic [6:0] exp_sw(int st);
      if (st == M_CHG) return 7'b0000111;
      if (st == M_XFR) return 7'b1111000;
      return 7'b0000000;
   endfunction

   function automatic logic exp_ss(int st, int ssc);
      return (st != M_OFF) && (ssc != SS);
   endfunction

   function automatic logic exp_pg(int st, int ssc, logic e, logic ov, logic oc);
      return (st != M_OFF) && (ssc == SS) && e && !ov && !oc;
   endfunction

   task automatic check(string req, string what, int act, int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
      end
   endtask

   task automatic compare_all();
      check(cur_req, "sw_en", int'(sw_en), int'(exp_sw(m_st)));
      check(cur_req, "ss_active", int'(ss_active), int'(exp_ss(m_st, m_ss)));
      check(cur_req, "pgood", int'(pgood), int'(exp_pg(m_st, m_ss, en, ovp, ocp)));
   endtask

   // One cycle: compare at the falling edge, then apply the next inputs.
   task automatic step(logic e, logic vh, logic ov, logic oc);
      @(negedge clk);
      compare_all();
      en = e; vdd_hi = vh; ovp = ov; ocp = oc;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
      finish_run();
   end

   initial begin
      int ss_high;
      int run_len;
      int max_run;
      int prev_xfr;
      void'($urandom(32'd4711));

      // R1: reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      check("R1", "sw_en in reset", int'(sw_en), 0);
      check("R1", "ss_active in reset", int'(ss_active), 0);
      check("R1", "pgood in reset", int'(pgood), 0);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b0, 1'b0);

      // R4 R5: start-up with soft-start; R2 after it ends
      cur_req = "R4 R5";
      ss_high = 0;
      for (int i = 0; i < SS + 40; i++) begin
         step(1'b1, 1'b0, 1'b0, 1'b0);
         if (ss_active) ss_high++;
      end
      @(negedge clk);
      if (ss_active) ss_high++;
      check("R5", "soft-start cycles", ss_high, SS);
      cur_req = "R2 R3";
      for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 1'b0, 1'b0);

      // R6: over-voltage hold with high supply
      cur_req = "R6";
      max_run = 0; run_len = 0;
      for (int i = 0; i < 40; i++) begin
         step(1'b1, 1'b1, 1'b1, 1'b0);
         run_len = (sw_en == 7'b0000111) ? run_len + 1 : 0;
         if (run_len > max_run) max_run = run_len;
      end
      check("R6", "charge phase held beyond CHG", int'(max_run >= 25), 1);
      // R6: flag ignored for sequencing with low supply; R8 pgood drops
      cur_req = "R6 R8";
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b1, 1'b0);

      // R7: over-current pulses
      cur_req = "R7";
      for (int i = 0; i < 120; i++) step(1'b1, 1'b0, 1'b0, ($urandom % 4) == 0);

      // R8: pgood under flag toggles
      cur_req = "R8";
      for (int i = 0; i < 60; i++)
         step(1'b1, 1'($urandom % 2), ($urandom % 3) == 0, ($urandom % 5) == 0);

      // R9: disable, single-cycle drop, restart
      cur_req = "R9";
      step(1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      check("R9", "sw_en off after disable", int'(sw_en), 0);
      check("R9", "pgood off after disable", int'(pgood), 0);
      for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, 1'b0);

      // R2 R3 R4: constrained random traffic, including a direct overlap scan
      cur_req = "R2 R3 R4";
      prev_xfr = 0;
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 200) != 0, 1'($urandom % 2),
              ($urandom % 6) == 0, ($urandom % 9) == 0);
         if ((sw_en[2:0] != 0) && (sw_en[6:3] != 0))
            check("R3", "groups overlap", 1, 0);
         if (prev_xfr && (sw_en[2:0] != 0))
            check("R3", "charge right after transfer", 1, 0);
         prev_xfr = (sw_en[6:3] != 0);
      end
      @(negedge clk);
      compare_all();
      finish_run();
   end

endmodule